// File: doc/BRIEF.md
# ADC Result Holding Register With Read-Order Lock

This block sits between a successive-approximation converter core and an 8-bit processor bus. Each time the core finishes a conversion it pulses a valid strobe with a 10-bit result. The block keeps that value and shows it to the bus as two bytes, a low byte and a high byte. An alignment select chooses how the 10 bits are packed into the two bytes. Every finished conversion also raises a completion flag, and software clears the flag by writing a one.

Software reads a full result as two bus cycles, the low byte first and then the high byte. A low-byte read locks the stored value, so both bytes are guaranteed to come from one conversion. While the lock is held, a result that arrives is thrown away, but its completion flag is still raised. The high-byte read releases the lock. When only 8 bits are needed in left-aligned mode, software can read the high byte alone; this never engages the lock.

Top module: `adc_result_regs`

## Requirements
- R1: After reset the completion flag is 0, both byte views read 0x00 and the lock is released.
- R2: With `align_left` = 0 the high byte is {6'b0, r[9:8]} and the low byte is r[7:0]. `rd_data` shows the high byte while `rd_hi` is 1 and the low byte otherwise.
- R3: With `align_left` = 1 the high byte is r[9:2] and the low byte is {r[1:0], 6'b0}.
- R4: A change of `align_left` changes `rd_data` in the same cycle, with no new conversion.
- R5: When `res_valid` is high, the lock is released and `rd_lo` is low, `res_data` is stored at that clock edge.
- R6: A cycle with `rd_lo` high sets the lock. While the lock is held, or in the same cycle as `rd_lo`, a result is discarded and neither byte changes.
- R7: A cycle with `rd_hi` high releases the lock. A result that arrives in that same cycle is stored.
- R8: A high-byte read with no earlier low-byte read leaves the lock released, so the next result is stored.
- R9: Every `res_valid` pulse sets `irq_flag` on the following cycle, including pulses whose result is discarded.
- R10: A `flag_clr` pulse clears `irq_flag` on the next cycle. If `res_valid` is high in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Conversion-finished strobe from the core |
| res_data | input | 10 | Conversion value, sampled with `res_valid` |
| align_left | input | 1 | 1 = left-aligned byte packing, 0 = right-aligned |
| rd_lo | input | 1 | Bus read strobe for the low byte |
| rd_hi | input | 1 | Bus read strobe for the high byte |
| flag_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| rd_data | output | 8 | Selected byte of the stored result |
| irq_flag | output | 1 | Conversion-complete interrupt flag |

## Verification
The assertions assume that the bus decoder never raises `rd_lo` and `rd_hi` in the same cycle. One property checks this assumption directly. The random stimulus draws a single read kind per cycle, so the two strobes stay exclusive. Every other input is free to take any value in any cycle. This includes a result arriving in the same cycle as either read, or in the same cycle as a flag clear, and the directed cases force each of those collisions at least once.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;
  localparam int PAD_W  = 2 * BYTE_W - RES_W;

  // High byte of the stored result for the given packing.
  function automatic logic [BYTE_W-1:0] view_hi(input logic [RES_W-1:0] r,
                                                 input logic left);
    logic [BYTE_W-1:0] v;
    if (left) v = r[RES_W-1 -: BYTE_W];
    else      v = {{PAD_W{1'b0}}, r[RES_W-1:BYTE_W]};
    return v;
  endfunction

  // Low byte of the stored result for the given packing.
  function automatic logic [BYTE_W-1:0] view_lo(input logic [RES_W-1:0] r,
                                                 input logic left);
    logic [BYTE_W-1:0] v;
    if (left) v = {r[RES_W-BYTE_W-1:0], {PAD_W{1'b0}}};
    else      v = r[BYTE_W-1:0];
    return v;
  endfunction
endpackage

// File: rtl/res_lock.sv
module res_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic lock_q,
  output logic wr_ok
);
  // The high-byte read ends the pair, so a result arriving with it is safe.
  assign wr_ok = !rd_lo && (!lock_q || rd_hi);

  always_ff @(posedge clk) begin
    if (!rst_n)     lock_q <= 1'b0;
    else if (rd_hi) lock_q <= 1'b0;
    else if (rd_lo) lock_q <= 1'b1;
  end
endmodule

// File: rtl/res_store.sv
module res_store
  import adc_res_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RES_W-1:0] din,
  output logic [RES_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= din;
  end
endmodule

// File: rtl/res_flag.sv
module res_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/byte_view.sv
module byte_view
  import adc_res_pkg::*;
(
  input  logic [RES_W-1:0]  res,
  input  logic              left,
  input  logic              hi_sel,
  output logic [BYTE_W-1:0] dout
);
  logic [BYTE_W-1:0] hi_b;
  logic [BYTE_W-1:0] lo_b;

  assign hi_b = view_hi(res, left);
  assign lo_b = view_lo(res, left);
  assign dout = hi_sel ? hi_b : lo_b;
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_res_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              align_left,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic              flag_clr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              irq_flag
);
  logic             lock_q;
  logic             wr_ok;
  logic             upd_en;
  logic             drop_evt;
  logic [RES_W-1:0] res_q;

  // Named events for the checker.
  assign upd_en   = res_valid && wr_ok;
  assign drop_evt = res_valid && !wr_ok;

  res_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_lo  (rd_lo),
    .rd_hi  (rd_hi),
    .lock_q (lock_q),
    .wr_ok  (wr_ok)
  );

  res_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (upd_en),
    .din   (res_data),
    .q     (res_q)
  );

  res_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (res_valid),
    .clr   (flag_clr),
    .flag  (irq_flag)
  );

  byte_view u_view (
    .res    (res_q),
    .left   (align_left),
    .hi_sel (rd_hi),
    .dout   (rd_data)
  );
endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk
  import adc_res_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic [RES_W-1:0] res_data,
  input logic             rd_lo,
  input logic             rd_hi,
  input logic             flag_clr,
  input logic             irq_flag,
  input logic             lock_q,
  input logic             upd_en,
  input logic             drop_evt,
  input logic [RES_W-1:0] res_q
);
  // Input assumption: the two read strobes are exclusive.
  p_single_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_lo && rd_hi));

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> res_q == $past(res_data));

  p_lock_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && !rd_hi |=> lock_q);

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !rd_hi |=> $stable(res_q));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !lock_q);

  p_hi_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q && !rd_lo |=> !lock_q);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> irq_flag);

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(res_q) && irq_flag);

  p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !res_valid |=> !irq_flag);
endmodule

bind adc_result_regs adc_result_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .res_data  (res_data),
  .rd_lo     (rd_lo),
  .rd_hi     (rd_hi),
  .flag_clr  (flag_clr),
  .irq_flag  (irq_flag),
  .lock_q    (lock_q),
  .upd_en    (upd_en),
  .drop_evt  (drop_evt),
  .res_q     (res_q)
);

// File: tb/test_adc_result_regs.sv
module test_adc_result_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       res_valid;
  logic [9:0] res_data;
  logic       align_left;
  logic       rd_lo;
  logic       rd_hi;
  logic       flag_clr;
  logic [7:0] rd_data;
  logic       irq_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Bench-side model state.
  logic [9:0] m_res;
  logic       m_lock;
  logic       m_flag;

  always #10 clk = ~clk;

  adc_result_regs i_adc_result_regs (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .align_left(align_left), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .flag_clr(flag_clr), .rd_data(rd_data), .irq_flag(irq_flag)
  );

  // Byte packing, written with shifts and masks.
  function automatic logic [7:0] exp_byte(input logic [9:0] r, input logic left,
                                          input logic hi);
    int v = int'(r);
    if (left) v = hi ? (v >> 2) : ((v << 6) & 'hFF);
    else      v = hi ? (v / 256) : (v % 256);
    return 8'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check the byte view before the edge,
  // advance the model at the edge, check the flag at the next negedge.
  task automatic cyc(input bit v, input logic [9:0] d, input bit al,
                     input bit lo, input bit hi, input bit cl,
                     input string dtag, input string ftag);
    logic [7:0] eb;
    bit wr_ok;
    res_valid = v; res_data = d; align_left = al;
    rd_lo = lo; rd_hi = hi; flag_clr = cl;
    #1;
    eb = exp_byte(m_res, al, hi);
    chk(rd_data == eb, dtag, rd_data, eb);
    @(posedge clk);
    wr_ok = !lo && (!m_lock || hi);
    if (v && wr_ok) m_res = d;
    if (hi) m_lock = 1'b0;
    else if (lo) m_lock = 1'b1;
    m_flag = v || (m_flag && !cl);
    @(negedge clk);
    chk(irq_flag == m_flag, ftag, irq_flag, m_flag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    bit al;
    rst_n = 1'b0; res_valid = 0; res_data = 0; align_left = 0;
    rd_lo = 0; rd_hi = 0; flag_clr = 0;
    m_res = '0; m_lock = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(irq_flag == 1'b0, "R1", irq_flag, 0);
    cyc(0, 10'h000, 0, 0, 1, 0, "R1", "R1");
    cyc(0, 10'h000, 1, 0, 0, 0, "R1", "R1");
    // R5 capture, then R2 right-aligned reads
    cyc(1, 10'h2A5, 0, 0, 0, 0, "R5", "R9");
    cyc(0, 10'h000, 0, 0, 1, 0, "R2", "R9");
    cyc(0, 10'h000, 0, 1, 0, 0, "R2", "R9");
    cyc(0, 10'h000, 0, 0, 1, 0, "R2", "R9");
    // R3 left-aligned reads (high first, then low locks; high releases)
    cyc(0, 10'h000, 1, 0, 1, 0, "R3", "R9");
    cyc(0, 10'h000, 1, 1, 0, 0, "R3", "R9");
    cyc(0, 10'h000, 1, 0, 1, 0, "R3", "R9");
    // R4 alignment flip with no conversion
    cyc(0, 10'h000, 0, 0, 0, 1, "R4", "R10");
    cyc(0, 10'h000, 1, 0, 0, 0, "R4", "R10");
    // R6 lock: low read, result arrives while locked, high still old
    cyc(0, 10'h000, 0, 1, 0, 0, "R6", "R10");
    cyc(1, 10'h155, 0, 0, 0, 0, "R6", "R9");
    cyc(0, 10'h000, 0, 0, 1, 0, "R6", "R9");
    cyc(0, 10'h000, 0, 0, 0, 0, "R6", "R9");
    // R6 result in the same cycle as the low read
    cyc(1, 10'h0FF, 0, 1, 0, 0, "R6", "R9");
    cyc(0, 10'h000, 0, 0, 1, 0, "R6", "R9");
    cyc(0, 10'h000, 0, 0, 0, 0, "R6", "R9");
    // R7 result in the same cycle as the releasing high read
    cyc(0, 10'h000, 0, 1, 0, 0, "R7", "R9");
    cyc(1, 10'h3C3, 0, 0, 1, 0, "R7", "R9");
    cyc(0, 10'h000, 0, 0, 0, 0, "R7", "R9");
    cyc(0, 10'h000, 0, 0, 1, 0, "R7", "R9");
    // R8 high-only read leaves the lock open
    cyc(0, 10'h000, 1, 0, 1, 0, "R8", "R9");
    cyc(1, 10'h111, 1, 0, 0, 0, "R8", "R9");
    cyc(0, 10'h000, 0, 0, 0, 0, "R8", "R9");
    // R10 clear alone, then clear colliding with a new result
    cyc(0, 10'h000, 0, 0, 0, 1, "R2", "R10");
    cyc(1, 10'h001, 0, 0, 0, 1, "R2", "R10");
    cyc(0, 10'h000, 0, 0, 0, 0, "R2", "R10");
    // Constrained random traffic with a fixed seed
    seed = 32'd1234;
    void'($urandom(seed));
    al = 0;
    for (int i = 0; i < 3000; i++) begin
      int unsigned rk = $urandom_range(99);
      bit lo = (rk < 15);
      bit hi = (rk >= 15 && rk < 30);
      bit v  = ($urandom_range(99) < 30);
      bit cl = ($urandom_range(99) < 10);
      if ($urandom_range(99) < 5) al = !al;
      cyc(v, 10'($urandom), al, lo, hi, cl, al ? "R3" : "R2",
          v ? "R9" : "R10");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule